// File: doc/BRIEF.md
# Atomic memory operation unit

This unit performs one atomic read-modify-write on a memory location for a simple in-order pipeline. The pipeline hands it a 32-bit instruction word, an address and a 64-bit register operand, together with a start pulse. The unit decodes the instruction and works out the operation and the access width. It reads the old value through a single-port request/response memory interface, computes the new value and writes it back. It then returns the old value for the destination register.

A memory-side arbiter watches the busy output. While busy is high, no other requestor may reach memory between the read and the write. Instructions that are not recognised, doubleword operations issued while 64-bit mode is off, and unaligned addresses are rejected. A rejected instruction produces no memory traffic. The unit reports the rejection with a done pulse and one error flag.

Top module: `amo_unit`

## Requirements
- R1: An instruction is accepted only when bits 31:25 equal 7'h7a, bits 14:12 equal 2 or 3, and bits 11:8 are zero. Any other value raises err_unimp. Bits 24:15 and 4:0 have no effect on behaviour.
- R2: Bits 7:5 select the operation: 0 add, 1 swap, 2 and, 3 or, 4 signed min, 5 signed max, 6 unsigned min, 7 unsigned max. Swap stores the operand unchanged. Every other operation stores the operand combined with the old memory value.
- R3: Bits 14:12 = 2 select a word access (mem_dw = 0) and 3 a doubleword access (mem_dw = 1). For a word access:
  - only operand[31:0] takes part in the operation;
  - mem_rdata[63:32] is ignored;
  - the store places the result on mem_wdata[31:0], with mem_wdata[63:32] = 0.
- R4: For a word access, the old value returned on result is sign-extended to 64 bits for operations 0 to 5. It is zero-extended for operations 6 and 7. A doubleword access returns the full 64-bit old value.
- R5: Signed min/max compare the two values as two's-complement numbers of the access width. Unsigned min/max compare them as unsigned numbers of the access width.
- R6: A doubleword instruction while mode64 = 0 raises err_illegal. Word instructions are unaffected by mode64.
- R7: A word access to an address with addr[1:0] != 0, or a doubleword access with addr[2:0] != 0, raises err_misalign.
- R8: Error priority is err_unimp over err_illegal over err_misalign, and at most one flag is high.
  - A rejected instruction raises no mem_req and changes no memory.
  - It leaves result at its previous value.
  - done rises one cycle after the start is taken.
- R9: An accepted instruction proceeds as follows:
  - It holds a read request (mem_req = 1, mem_we = 0) until the cycle mem_rvalid is high.
  - It then holds a write request (mem_we = 1) until the cycle mem_wack is high.
  - It then pulses done for exactly one cycle, with the old value on result.
  - With zero-wait memory, done is seen three cycles after start is taken.
- R10: busy is high from the read phase through the write phase. A start seen while the unit is not idle is ignored.
- R11: After reset:
  - busy, done, mem_req and all error flags are low;
  - result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| insn | input | 32 | Instruction word |
| addr | input | ADDR_W | Byte address of the memory location |
| operand | input | DATA_W | Register operand |
| mode64 | input | 1 | Doubleword operations permitted |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_dw | output | 1 | Access is a doubleword (else word) |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read response valid |
| mem_wack | input | 1 | Write acknowledge |
| busy | output | 1 | Read-modify-write in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Old value for the destination register |
| err_unimp | output | 1 | Unrecognised instruction (valid with done) |
| err_illegal | output | 1 | Doubleword without 64-bit mode (valid with done) |
| err_misalign | output | 1 | Unaligned address (valid with done) |

## Verification
A new start request can coincide with the memory handshakes of an operation already in flight. The bench provokes this by holding start high from launch until done is observed. This covers the cycle in which the read response arrives and the cycle in which the write acknowledgement arrives. The memory model counts read and write responses, and exactly one of each is expected per accepted instruction. A second coincidence is a read response in the very first cycle of the request, followed at once by the write acknowledgement. The bench judges that case by the cycle at which done appears, compared against the value expected for zero-wait and for three-wait memory.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int INSN_W      = 32;
  localparam logic [6:0] MAJOR_AMO = 7'h7a;
  localparam logic [2:0] WIDTH_WORD  = 3'd2;
  localparam logic [2:0] WIDTH_DWORD = 3'd3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SWAP = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_MIN  = 3'd4,
    OP_MAX  = 3'd5,
    OP_MINU = 3'd6,
    OP_MAXU = 3'd7
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } amo_state_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_UNIMP    = 2'd1,
    ERR_ILLEGAL  = 2'd2,
    ERR_MISALIGN = 2'd3
  } amo_err_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic [2:0]        addr_lo,
  input  logic              mode64,
  output amo_op_e           op,
  output logic              is_dw,
  output amo_err_e          err
);

  logic major_ok;
  logic width_ok;
  logic pad_ok;
  logic misaligned;
  logic unused_fields;

  // register specifier fields play no part in decode
  assign unused_fields = ^{insn[24:15], insn[4:0]};

  assign major_ok   = (insn[31:25] == MAJOR_AMO);
  assign width_ok   = (insn[14:12] == WIDTH_WORD) || (insn[14:12] == WIDTH_DWORD);
  assign pad_ok     = (insn[11:8] == 4'd0);
  assign is_dw      = (insn[14:12] == WIDTH_DWORD);
  assign op         = amo_op_e'(insn[7:5]);
  assign misaligned = is_dw ? (addr_lo != 3'd0) : (addr_lo[1:0] != 2'd0);

  always_comb begin
    if (!(major_ok && width_ok && pad_ok)) begin
      err = ERR_UNIMP;
    end else if (is_dw && !mode64) begin
      err = ERR_ILLEGAL;
    end else if (misaligned) begin
      err = ERR_MISALIGN;
    end else begin
      err = ERR_NONE;
    end
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op,
  input  logic              is_dw,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] new_val,
  output logic [DATA_W-1:0] ret_val
);

  localparam int HALF = DATA_W / 2;

  logic              unsigned_op;
  logic [DATA_W-1:0] a_x;
  logic [DATA_W-1:0] b_x;
  logic [DATA_W-1:0] comb;
  logic              lt_s;
  logic              lt_u;

  assign unsigned_op = (op == OP_MINU) || (op == OP_MAXU);

  // Widen word operands once; the same widened old value is what returns.
  always_comb begin
    if (is_dw) begin
      a_x = operand;
      b_x = old_val;
    end else if (unsigned_op) begin
      a_x = {{HALF{1'b0}}, operand[HALF-1:0]};
      b_x = {{HALF{1'b0}}, old_val[HALF-1:0]};
    end else begin
      a_x = {{HALF{operand[HALF-1]}}, operand[HALF-1:0]};
      b_x = {{HALF{old_val[HALF-1]}}, old_val[HALF-1:0]};
    end
  end

  assign lt_s = ($signed(a_x) < $signed(b_x));
  assign lt_u = (a_x < b_x);

  always_comb begin
    unique case (op)
      OP_ADD:  comb = a_x + b_x;
      OP_SWAP: comb = a_x;
      OP_AND:  comb = a_x & b_x;
      OP_OR:   comb = a_x | b_x;
      OP_MIN:  comb = lt_s ? a_x : b_x;
      OP_MAX:  comb = lt_s ? b_x : a_x;
      OP_MINU: comb = lt_u ? a_x : b_x;
      default: comb = lt_u ? b_x : a_x;
    endcase
  end

  assign new_val = is_dw ? comb : {{HALF{1'b0}}, comb[HALF-1:0]};
  assign ret_val = b_x;

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic reject,
  input  logic rvalid,
  input  logic wack,
  output logic busy,
  output logic req,
  output logic we,
  output logic done,
  output logic launch,
  output logic take_rd,
  output logic finish
);

  amo_state_e state_q;
  amo_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = reject ? ST_DONE : ST_READ;
      ST_READ:  if (rvalid) state_d = ST_WRITE;
      ST_WRITE: if (wack) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign req     = busy;
  assign we      = (state_q == ST_WRITE);
  assign done    = (state_q == ST_DONE);
  assign launch  = (state_q == ST_IDLE) && start;
  assign take_rd = (state_q == ST_READ) && rvalid;
  assign finish  = (state_q == ST_WRITE) && wack;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !rvalid) |=> (req && !we)); // R9
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we) |-> $past(rvalid)); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && reject) |=> (done && !req)); // R8
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done)); // R10

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] operand,
  input  logic              mode64,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  input  logic              mem_wack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              err_unimp,
  output logic              err_illegal,
  output logic              err_misalign
);

  localparam int HALF = DATA_W / 2;

  amo_op_e           dec_op;
  logic              dec_dw;
  amo_err_e          dec_err;

  amo_op_e           op_q;
  logic              dw_q;
  amo_err_e          err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] operand_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] result_q;

  logic              launch;
  logic              take_rd;
  logic              finish;
  logic [DATA_W-1:0] alu_new;
  logic [DATA_W-1:0] alu_ret;

  amo_decode u_decode (
    .insn    (insn),
    .addr_lo (addr[2:0]),
    .mode64  (mode64),
    .op      (dec_op),
    .is_dw   (dec_dw),
    .err     (dec_err)
  );

  amo_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .reject  (dec_err != ERR_NONE),
    .rvalid  (mem_rvalid),
    .wack    (mem_wack),
    .busy    (busy),
    .req     (mem_req),
    .we      (mem_we),
    .done    (done),
    .launch  (launch),
    .take_rd (take_rd),
    .finish  (finish)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .is_dw   (dw_q),
    .operand (operand_q),
    .old_val (old_q),
    .new_val (alu_new),
    .ret_val (alu_ret)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_ADD;
      dw_q      <= 1'b0;
      err_q     <= ERR_NONE;
      addr_q    <= '0;
      operand_q <= '0;
      old_q     <= '0;
      result_q  <= '0;
    end else begin
      if (launch) begin
        op_q      <= dec_op;
        dw_q      <= dec_dw;
        err_q     <= dec_err;
        addr_q    <= addr;
        operand_q <= operand;
      end
      if (take_rd) begin
        old_q <= mem_rdata;
      end
      if (finish) begin
        result_q <= alu_ret;
      end
    end
  end

  assign mem_dw       = dw_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = mem_we ? alu_new : '0;
  assign result       = result_q;
  assign err_unimp    = done && (err_q == ERR_UNIMP);
  assign err_illegal  = done && (err_q == ERR_ILLEGAL);
  assign err_misalign = done && (err_q == ERR_MISALIGN);

  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_unimp, err_illegal, err_misalign})); // R8
  AST_ERROR_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_unimp || err_illegal || err_misalign)) |-> $past(!busy)); // R8
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_dw) |-> (mem_wdata[DATA_W-1:HALF] == '0)); // R3
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_dw ? (mem_addr[2:0] == 3'd0) : (mem_addr[1:0] == 2'd0))); // R7
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish) |=> $stable(result)); // R8

endmodule

// File: tb/amo_unit_test.sv
`timescale 1ns/1ps
module amo_unit_test;

  localparam int ADDR_W = 32;
  localparam int DW     = 64;
  localparam int WD     = 1000;

  typedef struct packed {
    logic [31:0] insn;
    logic [31:0] addr;
    logic [63:0] a;
    logic        m64;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [63:0] exp_res;
    logic [31:0] exp_lo;
    logic [31:0] exp_hi;
    logic [1:0]  exp_err;   // 0 none, 1 unimp, 2 illegal, 3 misalign
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{32'hF5FFA01F, 32'h10, 64'hFFFFFFFF_00000005, 1'b1, 32'h00000010, 32'h11111111, 64'h00000000_00000010, 32'h00000015, 32'h11111111, 2'd0},
    '{32'hF4002020, 32'h10, 64'h12345678_9ABCDEF0, 1'b1, 32'h80000001, 32'h22222222, 64'hFFFFFFFF_80000001, 32'h9ABCDEF0, 32'h22222222, 2'd0},
    '{32'hF4002040, 32'h10, 64'h00000000_0F0F0F0F, 1'b1, 32'hFF00FF00, 32'h33333333, 64'hFFFFFFFF_FF00FF00, 32'h0F000F00, 32'h33333333, 2'd0},
    '{32'hF4002060, 32'h10, 64'h00000000_000000F0, 1'b1, 32'h8000000F, 32'h44444444, 64'hFFFFFFFF_8000000F, 32'h800000FF, 32'h44444444, 2'd0},
    '{32'hF4002080, 32'h10, 64'h00000000_FFFFFFFE, 1'b1, 32'h00000003, 32'h55555555, 64'h00000000_00000003, 32'hFFFFFFFE, 32'h55555555, 2'd0},
    '{32'hF40020A0, 32'h10, 64'h00000000_00000001, 1'b1, 32'h80000000, 32'h66666666, 64'hFFFFFFFF_80000000, 32'h00000001, 32'h66666666, 2'd0},
    '{32'hF40020C0, 32'h10, 64'h00000000_00000001, 1'b1, 32'h80000000, 32'h77777777, 64'h00000000_80000000, 32'h00000001, 32'h77777777, 2'd0},
    '{32'hF40020E0, 32'h10, 64'hFFFFFFFF_00000001, 1'b1, 32'hFFFFFFF0, 32'h88888888, 64'h00000000_FFFFFFF0, 32'hFFFFFFF0, 32'h88888888, 2'd0},
    '{32'hF4003000, 32'h18, 64'h00000001_00000001, 1'b1, 32'hFFFFFFFF, 32'h00000000, 64'h00000000_FFFFFFFF, 32'h00000000, 32'h00000002, 2'd0},
    '{32'hF40030A0, 32'h18, 64'h7FFFFFFF_FFFFFFFF, 1'b1, 32'h00000000, 32'h80000000, 64'h80000000_00000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 2'd0},
    '{32'hF40030C0, 32'h18, 64'hFFFFFFFF_FFFFFFFF, 1'b1, 32'h00000000, 32'h00000001, 64'h00000001_00000000, 32'h00000000, 32'h00000001, 2'd0},
    '{32'hF4003020, 32'h18, 64'hCAFEF00D_12345678, 1'b1, 32'h89ABCDEF, 32'h01234567, 64'h01234567_89ABCDEF, 32'h12345678, 32'hCAFEF00D, 2'd0},
    '{32'hF4003080, 32'h18, 64'hFFFFFFFF_FFFFFFFF, 1'b1, 32'h00000005, 32'h00000000, 64'h00000000_00000005, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd0},
    '{32'hF4003040, 32'h18, 64'hFFFF0000_FFFF0000, 1'b1, 32'h9ABCDEF0, 32'h12345678, 64'h12345678_9ABCDEF0, 32'h9ABC0000, 32'h12340000, 2'd0},
    '{32'hF4003060, 32'h18, 64'h00000001_00000001, 1'b1, 32'h20000000, 32'h10000000, 64'h10000000_20000000, 32'h20000001, 32'h10000001, 2'd0},
    '{32'hF40030E0, 32'h18, 64'h00000000_00000010, 1'b1, 32'h0000000F, 32'h00000000, 64'h00000000_0000000F, 32'h00000010, 32'h00000000, 2'd0},
    '{32'hF4001000, 32'h10, 64'h0, 1'b1, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd1},
    '{32'hF4002100, 32'h10, 64'h0, 1'b1, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd1},
    '{32'hF6002000, 32'h10, 64'h0, 1'b1, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd1},
    '{32'hF4003000, 32'h18, 64'h0, 1'b0, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd2},
    '{32'hF4003000, 32'h14, 64'h0, 1'b0, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd2},
    '{32'hF4002000, 32'h12, 64'h0, 1'b1, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd3},
    '{32'hF4003000, 32'h14, 64'h0, 1'b1, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd3},
    '{32'hF4001000, 32'h13, 64'h0, 1'b1, 32'hAAAAAAAA, 32'hBBBBBBBB, 64'h00000000_0000000F, 32'hAAAAAAAA, 32'hBBBBBBBB, 2'd1},
    '{32'hF4002000, 32'h10, 64'h00000000_00000001, 1'b0, 32'h00000002, 32'hCCCCCCCC, 64'h00000000_00000002, 32'h00000003, 32'hCCCCCCCC, 2'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [31:0]       insn;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     operand;
  logic              mode64;
  logic              mem_req, mem_we, mem_dw;
  logic [ADDR_W-1:0] mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     mem_rdata;
  logic              mem_rvalid, mem_wack;
  logic              busy, done;
  logic [DW-1:0]     result;
  logic              err_unimp, err_illegal, err_misalign;

  logic [31:0] mem_m [16];
  int          lat;
  int          rd_cnt;
  int          wr_cnt;
  int          tests;
  int          fails;

  always #2 clk = ~clk;

  amo_unit #(.ADDR_W(ADDR_W), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .addr(addr),
    .operand(operand), .mode64(mode64), .mem_req(mem_req), .mem_we(mem_we),
    .mem_dw(mem_dw), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .mem_wack(mem_wack),
    .busy(busy), .done(done), .result(result), .err_unimp(err_unimp),
    .err_illegal(err_illegal), .err_misalign(err_misalign)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: upper half of a word read is junk the unit must ignore.
  task automatic responder();
    int wait_n = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_wack   = 1'b0;
      if (mem_req) begin
        if (wait_n >= lat) begin
          if (mem_we) begin
            mem_m[mem_addr[5:2]] = mem_wdata[31:0];
            if (mem_dw) mem_m[mem_addr[5:2] + 4'd1] = mem_wdata[63:32];
            mem_wack = 1'b1;
            wr_cnt++;
          end else begin
            mem_rdata = mem_dw ? {mem_m[mem_addr[5:2] + 4'd1], mem_m[mem_addr[5:2]]}
                               : {32'hDEADBEEF, mem_m[mem_addr[5:2]]};
            mem_rvalid = 1'b1;
            rd_cnt++;
          end
          wait_n = 0;
        end else begin
          wait_n++;
        end
      end else begin
        wait_n = 0;
      end
    end
  endtask

  // start stays high until done is seen, so it overlaps every handshake (R10)
  task automatic run_op(input logic [31:0] i, input logic [31:0] ad, input logic [63:0] a,
                        input logic m, output logic [63:0] res, output logic [1:0] ec,
                        output int cyc);
    @(negedge clk);
    insn = i; addr = ad; operand = a; mode64 = m; start = 1'b1;
    rd_cnt = 0; wr_cnt = 0; cyc = 0;
    while (!done && cyc < WD) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= WD) begin
      tests++; fails++;
      $display("FAIL R9: actual timeout expected done");
    end
    res = result;
    ec  = err_unimp ? 2'd1 : err_illegal ? 2'd2 : err_misalign ? 2'd3 : 2'd0;
    start = 1'b0;
    @(negedge clk);
    check("R9 done pulse width", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] res;
    logic [1:0]  ec;
    int          cyc;
    tests = 0; fails = 0; lat = 0;
    rst_n = 1'b0; start = 1'b0; insn = '0; addr = '0; operand = '0; mode64 = 1'b0;
    mem_rdata = '0; mem_rvalid = 1'b0; mem_wack = 1'b0;
    for (int k = 0; k < 16; k++) mem_m[k] = 32'h0;
    fork responder(); join_none
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", {63'd0, busy}, 64'd0);
    check("R11 done", {63'd0, done}, 64'd0);
    check("R11 mem_req", {63'd0, mem_req}, 64'd0);
    check("R11 errors", {61'd0, err_unimp, err_illegal, err_misalign}, 64'd0);
    check("R11 result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R1 R2 R3 R4 R5 R6 R7 R8 covered by the vectors
    for (int v = 0; v < NV; v++) begin
      int idx;
      idx = int'(VECS[v].addr[5:2]);
      mem_m[idx] = VECS[v].lo;
      mem_m[(idx + 1) % 16] = VECS[v].hi;
      run_op(VECS[v].insn, VECS[v].addr, VECS[v].a, VECS[v].m64, res, ec, cyc);
      check($sformatf("R2/R4 result vec%0d", v), res, VECS[v].exp_res);
      check($sformatf("R1/R6/R7/R8 error code vec%0d", v), {62'd0, ec}, {62'd0, VECS[v].exp_err});
      check($sformatf("R3/R5 mem low vec%0d", v), {32'd0, mem_m[idx]}, {32'd0, VECS[v].exp_lo});
      check($sformatf("R3 mem high vec%0d", v), {32'd0, mem_m[(idx + 1) % 16]}, {32'd0, VECS[v].exp_hi});
      if (VECS[v].exp_err == 2'd0) begin
        check($sformatf("R9 traffic vec%0d", v), {32'(rd_cnt), 32'(wr_cnt)}, {32'd1, 32'd1});
        check($sformatf("R9 zero-wait latency vec%0d", v), 64'(cyc), 64'd3);
      end else begin
        check($sformatf("R8 no traffic vec%0d", v), {32'(rd_cnt), 32'(wr_cnt)}, {32'd0, 32'd0});
        check($sformatf("R8 reject latency vec%0d", v), 64'(cyc), 64'd1);
      end
    end

    // R9 with wait states; R10 busy throughout
    lat = 3;
    mem_m[4] = 32'h00000007;
    fork
      run_op(32'hF4002000, 32'h10, 64'h1, 1'b1, res, ec, cyc);
      begin
        repeat (3) @(negedge clk);
        check("R10 busy during wait", {63'd0, busy}, 64'd1);
      end
    join
    check("R9 waited latency", 64'(cyc), 64'd9);
    check("R9 waited result", res, 64'h7);
    check("R9 waited store", {32'd0, mem_m[4]}, 64'h8);
    check("R10 single sequence", {32'(rd_cnt), 32'(wr_cnt)}, {32'd1, 32'd1});

    // R11 reset in the middle of an operation, then recovery
    lat = 6;
    @(negedge clk);
    insn = 32'hF4002000; addr = 32'h10; operand = 64'h1; mode64 = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R10 busy mid-op", {63'd0, busy}, 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 busy after reset", {62'd0, busy, mem_req}, 64'd0);
    check("R11 result after reset", result, 64'd0);
    rst_n = 1'b1;
    lat = 0;
    mem_m[4] = 32'h00000020;
    run_op(32'hF4002000, 32'h10, 64'h2, 1'b1, res, ec, cyc);
    check("R9 recovery result", res, 64'h20);
    check("R9 recovery store", {32'd0, mem_m[4]}, 64'h22);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule